// File: doc/BRIEF.md
# Aperture Page Translation Unit

This block turns bus addresses into physical addresses. A window of bus address space, the aperture, is remapped one 4 KB page at a time through an on-chip table of 32-bit page entries. Any address outside the window, or any address seen while translation is off, comes back unchanged with a 40-bit zero extension.

Software sets up the unit through two configuration words. One is a window base register: its 15 bits give the base in 32 MB steps. The other is a control word that holds an enable bit and a size order. The entry table is loaded through a separate write port.

Each lookup returns a registered result two cycles after the request. The unit keeps the entry from the most recent table read in a one-entry cache. A flush pulse discards that cached entry. After changing the table, software flushes so that later lookups see the new contents.

Top module: `apt_xlate`

## Requirements
- R1: After a synchronous active-low reset, the base register and control word are zero and `rsp_valid` is low. A request made next passes through untranslated, with `rsp_hit` low.
- R2: A request accepted on a clock edge produces exactly one response, with `rsp_valid` high, two edges later. `rsp_valid` is low on the edge in between and whenever no request was made two edges before.
- R3: Control word bit 0 enables translation. While it is clear, every address passes through with `rsp_hit` and `rsp_fault` low.
- R4: The window base is base-register bits 14:0 shifted left by 25. The window size is 32 MB shifted left by control bits 3:1, then clamped to DEPTH x 4 KB. An address hits when base <= address < base + clamped size.
- R5: A response with `rsp_hit` low returns the request address zero-extended to 40 bits, with `rsp_fault` low.
- R6: If the window base plus the unclamped size is greater than 4 GB, the window is absent and nothing hits. A sum of exactly 4 GB is allowed.
- R7: On a hit, the table index is (address - base) >> 12, and address bits 11:0 appear unchanged in `rsp_paddr[11:0]`.
- R8: On a hit whose entry has bit 0 set, `rsp_paddr[31:12]` = entry[31:12] and `rsp_paddr[39:32]` = entry[11:4]. Entry bit 1, the coherent flag, has no effect on the address.
- R9: On a hit whose entry has bit 0 clear, the response has `rsp_hit` and `rsp_fault` high and `rsp_paddr` equal to zero. `rsp_fault` is never high without `rsp_hit`.
- R10: A table write to the index that was last translated does not show in lookups of that index until a flush, or until a lookup of another index refills the cache.
- R11: A flush pulse empties the cached entry, so the next hit reads the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Selects the target: 0 = window base register, 1 = control word |
| cfg_wdata | input | 15 | Configuration data. The base uses bits 14:0. The control word uses bits 3:0: bit 0 is enable, bits 3:1 are the size order |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W (8) | Index of the entry being written |
| tbl_wdata | input | 32 | Entry value |
| flush | input | 1 | Empties the one-entry translation cache |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Response strobe, two cycles after the request |
| rsp_paddr | output | 40 | Translated or passed-through physical address |
| rsp_hit | output | 1 | Address fell inside an active window |
| rsp_fault | output | 1 | Hit on an entry whose valid bit is clear |

## Verification
A wrong window decode shows up on the next response as a flipped `rsp_hit` together with a zero-extended address where a remapped one was expected, or the reverse. The bench therefore probes both edges of the window, the clamp limit, and the 4 GB rejection boundary on both sides. A stale or wrongly tagged cache entry returns an address from an older entry. It can only be seen on a lookup of the same index, so the bench rewrites the entry just translated and then looks it up before the flush and again after it. Because every result is registered, any internal fault appears exactly two cycles after the request that exposes it.

// File: rtl/apt_pkg.sv
// Package: shared constants, config selector and page-entry layout for the
// aperture translation unit. Assumes 32-bit bus addresses, 40-bit physical
// addresses and 4 KB pages.
package apt_pkg;
    localparam int BUS_AW     = 32;
    localparam int PHYS_AW    = 40;
    localparam int PAGE_SH    = 12;
    localparam int GRAN_SH    = 25;
    localparam int BASE_W     = 15;
    localparam int ORDER_W    = 3;
    localparam int SPAN_W     = 41;
    localparam int ENT_W      = 32;

    typedef enum logic {
        SEL_WINBASE = 1'b0,
        SEL_CTRL    = 1'b1
    } cfg_sel_e;

    // Page entry layout: frame bits 31:12, high phys bits 11:4, flags 1:0.
    typedef struct packed {
        logic [19:0] frame_lo;
        logic [7:0]  frame_hi;
        logic [1:0]  rsvd;
        logic        coh;
        logic        vld;
    } pg_entry_t;

    // Physical page number (40-12 bits) recovered from an entry.
    function automatic logic [PHYS_AW-PAGE_SH-1:0] entry_ppn(input pg_entry_t e);
        return {e.frame_hi, e.frame_lo};
    endfunction
endpackage

// File: rtl/apt_cfg_regs.sv
// Configuration registers: the window base register and the control word.
// Derives the window base, the clamped span and the window-present flag.
// Assumes a single writer and that changes take effect on the next lookup.
module apt_cfg_regs
    import apt_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [BASE_W-1:0]    cfg_wdata,
    output logic                 xl_en,
    output logic [PHYS_AW-1:0]   win_base,
    output logic [SPAN_W-1:0]    win_span,
    output logic                 win_ok
);
    localparam logic [SPAN_W-1:0] CAP_BYTES = SPAN_W'(DEPTH) << PAGE_SH;
    localparam logic [SPAN_W-1:0] GRAN      = SPAN_W'(1) << GRAN_SH;
    localparam logic [SPAN_W-1:0] LIMIT_4G  = SPAN_W'(1) << BUS_AW;

    logic [BASE_W-1:0]  base_q;
    logic [ORDER_W-1:0] order_q;
    logic               en_q;
    logic [SPAN_W-1:0]  full_size;
    logic [SPAN_W-1:0]  win_end;

    // Register writes from the configuration port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= '0;
            en_q    <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_sel_e'(cfg_sel) == SEL_WINBASE) begin
                base_q <= cfg_wdata;
            end else begin
                en_q    <= cfg_wdata[0];
                order_q <= cfg_wdata[ORDER_W:1];
            end
        end
    end

    // Window geometry: base, unclamped size, presence test and clamp.
    always_comb begin
        win_base  = PHYS_AW'({base_q, GRAN_SH'(0)});
        full_size = GRAN << order_q;
        win_end   = {1'b0, win_base} + full_size;
        win_ok    = (win_end <= LIMIT_4G) && (full_size != '0);
        win_span  = (full_size > CAP_BYTES) ? CAP_BYTES : full_size;
        xl_en     = en_q;
    end

    // R6
    window_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_ok |-> (win_base + PHYS_AW'(win_span)) <= PHYS_AW'(LIMIT_4G));
endmodule

// File: rtl/apt_decode.sv
// Stage 1: compares the request with the window and registers the hit flag,
// the table index and the address. Assumes the window values are stable
// in the cycle of the request.
module apt_decode
    import apt_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [BUS_AW-1:0]    req_addr,
    input  logic                 xl_en,
    input  logic [PHYS_AW-1:0]   win_base,
    input  logic [SPAN_W-1:0]    win_span,
    input  logic                 win_ok,
    output logic                 s1_vld,
    output logic                 s1_hit,
    output logic [IDX_W-1:0]     s1_idx,
    output logic [BUS_AW-1:0]    s1_addr
);
    logic [SPAN_W-1:0] rel;
    logic              in_win;

    // Offset of the request from the window base, and the window test.
    always_comb begin
        rel    = SPAN_W'(req_addr) - {1'b0, win_base};
        in_win = xl_en && win_ok && !rel[SPAN_W-1] && (rel < win_span);
    end

    // Control half of stage 1, which is reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_hit <= 1'b0;
        end else begin
            s1_vld <= req_valid;
            s1_hit <= req_valid && in_win;
        end
    end

    // Data half of stage 1: index and address. These need no reset.
    always_ff @(posedge clk) begin
        s1_idx  <= rel[PAGE_SH +: IDX_W];
        s1_addr <= req_addr;
    end

    // R6
    hit_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_hit |-> $past(win_ok));
    // R3
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_hit |-> $past(xl_en));
    // R2
    hit_only_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_hit |-> s1_vld);
endmodule

// File: rtl/apt_entry_store.sv
// Stage 2: the page-entry table, the one-entry cache of the last read, and
// the registered response. Assumes software fills the entries before it
// enables translation and flushes after it rewrites an entry.
module apt_entry_store
    import apt_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tbl_we,
    input  logic [IDX_W-1:0]     tbl_idx,
    input  logic [ENT_W-1:0]     tbl_wdata,
    input  logic                 flush,
    input  logic                 s1_vld,
    input  logic                 s1_hit,
    input  logic [IDX_W-1:0]     s1_idx,
    input  logic [BUS_AW-1:0]    s1_addr,
    output logic                 rsp_valid,
    output logic [PHYS_AW-1:0]   rsp_paddr,
    output logic                 rsp_hit,
    output logic                 rsp_fault
);
    pg_entry_t        tbl [DEPTH];
    logic             c_vld;
    logic [IDX_W-1:0] c_idx;
    pg_entry_t        c_ent;
    logic             use_cache;
    pg_entry_t        sel_ent;

    // Table write port.
    always_ff @(posedge clk) begin
        if (tbl_we) tbl[tbl_idx] <= pg_entry_t'(tbl_wdata);
    end

    // Take the entry from the cache on a tag match, else from the table.
    always_comb begin
        use_cache = c_vld && !flush && (c_idx == s1_idx);
        sel_ent   = use_cache ? c_ent : tbl[s1_idx];
    end

    // Cache valid flag: a flush clears it, a table read sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)                             c_vld <= 1'b0;
        else if (flush)                         c_vld <= 1'b0;
        else if (s1_vld && s1_hit && !use_cache) c_vld <= 1'b1;
    end

    // Cache tag and data, loaded on every table read.
    always_ff @(posedge clk) begin
        if (!flush && s1_vld && s1_hit && !use_cache) begin
            c_idx <= s1_idx;
            c_ent <= tbl[s1_idx];
        end
    end

    // Response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= s1_vld;
            rsp_hit   <= s1_vld && s1_hit;
            rsp_fault <= s1_vld && s1_hit && !sel_ent.vld;
            if (!s1_hit)          rsp_paddr <= PHYS_AW'(s1_addr);
            else if (sel_ent.vld) rsp_paddr <= {entry_ppn(sel_ent), s1_addr[PAGE_SH-1:0]};
            else                  rsp_paddr <= '0;
        end
    end

    // R11
    flush_empties_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !c_vld);
    // R9
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_hit && rsp_paddr == '0));
    // R7
    hit_keeps_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !rsp_fault) |-> rsp_paddr[PAGE_SH-1:0] == $past(s1_addr[PAGE_SH-1:0]));
endmodule

// File: rtl/apt_xlate.sv
// Top level of the aperture page translation unit. It connects the config
// registers, the stage 1 window decode and the stage 2 entry store.
// The response follows a request by two cycles.
module apt_xlate
    import apt_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [BASE_W-1:0]    cfg_wdata,
    input  logic                 tbl_we,
    input  logic [IDX_W-1:0]     tbl_idx,
    input  logic [ENT_W-1:0]     tbl_wdata,
    input  logic                 flush,
    input  logic                 req_valid,
    input  logic [BUS_AW-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic [PHYS_AW-1:0]   rsp_paddr,
    output logic                 rsp_hit,
    output logic                 rsp_fault
);
    logic               xl_en;
    logic [PHYS_AW-1:0] win_base;
    logic [SPAN_W-1:0]  win_span;
    logic               win_ok;
    logic               s1_vld;
    logic               s1_hit;
    logic [IDX_W-1:0]   s1_idx;
    logic [BUS_AW-1:0]  s1_addr;

    apt_cfg_regs #(.DEPTH(DEPTH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .xl_en(xl_en), .win_base(win_base),
        .win_span(win_span), .win_ok(win_ok)
    );

    apt_decode #(.DEPTH(DEPTH)) u_dec (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .xl_en(xl_en), .win_base(win_base), .win_span(win_span), .win_ok(win_ok),
        .s1_vld(s1_vld), .s1_hit(s1_hit), .s1_idx(s1_idx), .s1_addr(s1_addr)
    );

    apt_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_wdata(tbl_wdata), .flush(flush), .s1_vld(s1_vld), .s1_hit(s1_hit),
        .s1_idx(s1_idx), .s1_addr(s1_addr), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault)
    );

    // R2
    fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 rsp_valid);
    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid, 2));
    // R5
    miss_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == PHYS_AW'($past(req_addr, 2)) && !rsp_fault));
endmodule

// File: tb/apt_xlate_tb.sv
`timescale 1ns/1ps
module apt_xlate_tb;
    localparam int DEPTH = 256;
    localparam int IDX_W = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [14:0] cfg_wdata = '0;
    logic        tbl_we = 1'b0;
    logic [IDX_W-1:0] tbl_idx = '0;
    logic [31:0] tbl_wdata = '0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [39:0] rsp_paddr;
    logic        rsp_hit;
    logic        rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    apt_xlate #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_wdata(tbl_wdata), .flush(flush), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_hit(rsp_hit), .rsp_fault(rsp_fault)
    );

    // Vector: {bus addr, expected paddr, expected hit, expected fault}.
    // Window base 64 MB (base reg 2), order 0, clamped to 1 MB.
    localparam int NV = 9;
    localparam logic [73:0] VEC [NV] = '{
        {32'h0400_0ABC, 40'hA0_12300ABC, 1'b1, 1'b0},
        {32'h0400_1FFF, 40'hA1_12301FFF, 1'b1, 1'b0},
        {32'h0400_3000, 40'hA3_12303000, 1'b1, 1'b0},
        {32'h0400_5123, 40'h00_00000000, 1'b1, 1'b1},
        {32'h040F_F7FF, 40'h9F_123FF7FF, 1'b1, 1'b0},
        {32'h03FF_FFFF, 40'h00_03FFFFFF, 1'b0, 1'b0},
        {32'h0410_0000, 40'h00_04100000, 1'b0, 1'b0},
        {32'h8000_1234, 40'h00_80001234, 1'b0, 1'b0},
        {32'h0400_0004, 40'hA0_12300004, 1'b1, 1'b0}
    };

    function automatic logic [31:0] ent_for(input int i, input bit v);
        return {20'(32'h12300 + i), 8'(32'hA0 + i), 2'b00, 1'b1, v};
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input bit sel, input logic [14:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic tbl_write(input int i, input logic [31:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = IDX_W'(i); tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Issues one request and checks the response two edges later (R2).
    task automatic lookup(input string req, input logic [31:0] a,
                          input logic [39:0] ep, input bit eh, input bit ef);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 no response after one edge", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        check("R2 response after two edges", 64'(rsp_valid), 64'd1);
        check({req, " paddr"}, 64'(rsp_paddr), 64'(ep));
        check({req, " hit"}, 64'(rsp_hit), 64'(eh));
        check({req, " fault"}, 64'(rsp_fault), 64'(ef));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and passthrough with the reset configuration
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R1 rsp_hit after reset", 64'(rsp_hit), 64'd0);
        lookup("R1 reset passthrough", 32'h0000_0ABC, 40'h00_00000ABC, 1'b0, 1'b0);

        for (int i = 0; i < 8; i++) tbl_write(i, ent_for(i, i != 5));
        tbl_write(255, ent_for(255, 1'b1));

        // R3: window set up but enable clear
        cfg_write(1'b0, 15'd2);
        cfg_write(1'b1, 15'h0);
        lookup("R3 disabled passthrough", 32'h0400_0ABC, 40'h00_04000ABC, 1'b0, 1'b0);

        // R4 R5 R7 R8 R9: vector table walk
        cfg_write(1'b1, 15'h1);
        for (int v = 0; v < NV; v++) begin
            lookup($sformatf("R4/R5/R7/R8/R9 vector %0d", v), VEC[v][73:42],
                   VEC[v][41:2], VEC[v][1], VEC[v][0]);
        end
        @(negedge clk);
        check("R2 idle gives no response", 64'(rsp_valid), 64'd0);

        // R4: largest order at base 0 is allowed (sum exactly 4 GB), clamped to table
        cfg_write(1'b0, 15'd0);
        cfg_write(1'b1, 15'hF);
        lookup("R4 order7 base0 hit", 32'h0000_2345, 40'hA2_12302345, 1'b1, 1'b0);
        lookup("R4 clamp edge miss", 32'h0010_0000, 40'h00_00100000, 1'b0, 1'b0);
        // R6: largest order at base 32 MB crosses 4 GB
        cfg_write(1'b0, 15'd1);
        lookup("R6 order7 base32M absent", 32'h0200_0000, 40'h00_02000000, 1'b0, 1'b0);
        // R6: top base 0xFE000000, 64 MB crosses, 32 MB ends at exactly 4 GB
        cfg_write(1'b0, 15'h7F);
        cfg_write(1'b1, 15'h3);
        lookup("R6 crossing window absent", 32'hFE00_0000, 40'h00_FE000000, 1'b0, 1'b0);
        cfg_write(1'b1, 15'h1);
        lookup("R6 window ending at 4 GB", 32'hFE00_0010, 40'hA0_12300010, 1'b1, 1'b0);

        // R10 R11: stale cache until flush; coherent bit clear in the new entry (R8)
        cfg_write(1'b0, 15'd2);
        lookup("R10 prime cache", 32'h0400_0000, 40'hA0_12300000, 1'b1, 1'b0);
        tbl_write(0, {20'hABCDE, 8'h55, 2'b00, 1'b0, 1'b1});
        lookup("R10 stale before flush", 32'h0400_0123, 40'hA0_12300123, 1'b1, 1'b0);
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        lookup("R11 new entry after flush", 32'h0400_0123, 40'h55_ABCDE123, 1'b1, 1'b0);
        tbl_write(1, {20'h11111, 8'h22, 2'b00, 1'b1, 1'b1});
        lookup("R10 other index refills", 32'h0400_0456, 40'h55_ABCDE456, 1'b1, 1'b0);
        lookup("R10 rewritten index read", 32'h0400_1456, 40'h22_11111456, 1'b1, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule